// File: doc/BRIEF.md
# Signed halfword multiply-accumulate unit

This unit computes the signed halfword multiply family for an integer datapath. It takes two 32-bit source words and a 32-bit accumulator word, and it returns one 32-bit result together with a saturation-style overflow flag that the flag logic can sticky-set. Each 16-bit multiplicand is taken from either the low or the high half of its source word. One position bit per operand makes that choice, so each operand is chosen on its own. The chosen half is treated as a two's-complement number.

A 4-bit operation code picks one of three operations:

- A 16x16 multiply whose product is added to the accumulator.
- A plain 16x16 multiply.
- A word-by-halfword multiply. It multiplies the whole first source word by a halfword of the second source word and keeps the middle 32 bits of the 48-bit product.

The unit reads no register file and checks no condition. The surrounding pipeline supplies the operand values and consumes the result. The result is registered once by default, and a valid strobe marks each cycle that delivers a new result.

Top module: `hmac_unit`

## Requirements
- R1: Operand halves are selected independently. `pos_a`/`pos_b` = 0 picks bits 15:0 and 1 picks bits 31:16 of `src_a`/`src_b`. The selected half is sign-extended from bit 15 before multiplying.
- R2: With `op_code` = 4'h8 the result is the signed 16x16 product plus `acc_in`, wrapping modulo 2^32.
- R3: For `op_code` 4'h8, `q_flag` is 1 exactly when product and `acc_in` have equal sign bits and the 32-bit sum's sign bit differs from them.
- R4: With `op_code` = 4'hB the result is the signed 16x16 product. `acc_in` has no effect and `q_flag` is 0.
- R5: With `op_code` = 4'h9 the result is bits 47:16 of signed `src_a` times the sign-extended half of `src_b` picked by `pos_b`. `pos_a` and `acc_in` have no effect, and `q_flag` is 0.
- R6: Any other `op_code` value with `in_valid` high produces no `out_valid` and leaves `result` and `q_flag` unchanged.
- R7: A legal operation presented with `in_valid` high appears on `result`/`q_flag` with `out_valid` high one clock later. Without one, `out_valid` is 0 and the outputs hold.
- R8: While `rst_n` is low, `out_valid`, `result` and `q_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op_code | input | 4 | 8: multiply-accumulate, 9: word-by-halfword, B: multiply |
| pos_a | input | 1 | Half of `src_a` to use (1 = upper) |
| pos_b | input | 1 | Half of `src_b` to use (1 = upper) |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| acc_in | input | 32 | Accumulator addend |
| out_valid | output | 1 | New result delivered this cycle |
| result | output | 32 | Computed result |
| q_flag | output | 1 | Accumulate overflow indication |

## Verification
Each source half is swept over zero, one, the largest positive value, the most negative value and minus one. These are crossed with every position pair and every operation.

- Sign-extension faults show up as wrong products of 0x8000 and 0xFFFF halves.
- A swapped half selection shows up because the upper and lower halves differ.
- The accumulator values 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF drive the sum across both overflow boundaries. This separates wrap from saturation and exposes an overflow rule that looks at the wrong operand.

Word-by-halfword vectors with a full 32-bit first operand catch a wrong slice of the 48-bit product. Illegal op codes and idle cycles confirm that the outputs hold their values.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  // Operation codes; the values are fixed by the instruction decoder.
  typedef enum logic [3:0] {
    OP_MAC  = 4'h8,
    OP_WMUL = 4'h9,
    OP_MUL  = 4'hB
  } hmac_op_e;
endpackage

// File: rtl/hmac_half_sel.sv
module hmac_half_sel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   word_in,
  input  logic                pick_hi,
  output logic [DATA_W/2-1:0] half_out
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    if (pick_hi) half_out = word_in[DATA_W-1:HALF_W];
    else         half_out = word_in[HALF_W-1:0];
  end
endmodule

// File: rtl/hmac_mult.sv
module hmac_mult #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   a_word,
  input  logic [DATA_W/2-1:0] a_half,
  input  logic [DATA_W/2-1:0] b_half,
  input  logic                word_mode,
  output logic [DATA_W-1:0]   prod
);
  localparam int HALF_W = DATA_W / 2;
  localparam int PROD_W = DATA_W + HALF_W;

  logic [DATA_W-1:0] a_ext;
  logic [PROD_W-1:0] a_wide;
  logic [PROD_W-1:0] b_wide;
  logic [PROD_W-1:0] full_prod;

  // One shared multiplier: the first operand is either the whole word or
  // the sign-extended half. Both operands are widened to the exact product
  // width, so a modulo multiply yields the signed product.
  always_comb begin
    if (word_mode) a_ext = a_word;
    else           a_ext = {{HALF_W{a_half[HALF_W-1]}}, a_half};
    a_wide    = {{HALF_W{a_ext[DATA_W-1]}}, a_ext};
    b_wide    = {{DATA_W{b_half[HALF_W-1]}}, b_half};
    full_prod = a_wide * b_wide;
    if (word_mode) prod = full_prod[PROD_W-1:HALF_W];
    else           prod = full_prod[DATA_W-1:0];
  end
endmodule

// File: rtl/hmac_accum.sv
module hmac_accum #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] prod,
  input  logic [DATA_W-1:0] acc,
  input  logic              acc_en,
  output logic [DATA_W-1:0] sum,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] raw_sum;

  always_comb begin
    raw_sum = prod + acc;
    if (acc_en) begin
      sum = raw_sum;
      ovf = (prod[MSB] == acc[MSB]) && (raw_sum[MSB] != prod[MSB]);
    end else begin
      sum = prod;
      ovf = 1'b0;
    end
  end
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_code,
  input  logic              pos_a,
  input  logic              pos_b,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] acc_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              q_flag
);
  import hmac_pkg::*;

  localparam int HALF_W = DATA_W / 2;

  logic              is_mac;
  logic              is_word;
  logic              is_legal;
  logic              load;
  logic [HALF_W-1:0] half_a;
  logic [HALF_W-1:0] half_b;
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] sum;
  logic              ovf;

  // Operation decode
  always_comb begin
    is_mac   = (op_code == OP_MAC);
    is_word  = (op_code == OP_WMUL);
    is_legal = is_mac || is_word || (op_code == OP_MUL);
    load     = in_valid && is_legal;
  end

  hmac_half_sel #(.DATA_W(DATA_W)) u_sel_a (
    .word_in (src_a),
    .pick_hi (pos_a),
    .half_out(half_a)
  );

  hmac_half_sel #(.DATA_W(DATA_W)) u_sel_b (
    .word_in (src_b),
    .pick_hi (pos_b),
    .half_out(half_b)
  );

  hmac_mult #(.DATA_W(DATA_W)) u_mult (
    .a_word   (src_a),
    .a_half   (half_a),
    .b_half   (half_b),
    .word_mode(is_word),
    .prod     (prod)
  );

  hmac_accum #(.DATA_W(DATA_W)) u_accum (
    .prod  (prod),
    .acc   (acc_in),
    .acc_en(is_mac),
    .sum   (sum),
    .ovf   (ovf)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [DATA_W-1:0] res_d, res_q;
      logic              q_d, q_q;
      logic              vld_q;

      // Next state: clock enable on a legal, valid operation
      always_comb begin
        res_d = res_q;
        q_d   = q_q;
        if (load) begin
          res_d = sum;
          q_d   = ovf;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q <= '0;
          q_q   <= 1'b0;
          vld_q <= 1'b0;
        end else begin
          res_q <= res_d;
          q_q   <= q_d;
          vld_q <= load;
        end
      end

      assign result    = res_q;
      assign q_flag    = q_q;
      assign out_valid = vld_q;
    end else begin : g_comb
      assign result    = sum;
      assign q_flag    = ovf && load;
      assign out_valid = load;
    end
  endgenerate
endmodule

// File: rtl/hmac_chk.sv
module hmac_chk #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        op_code,
  input logic              pos_a,
  input logic              pos_b,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [DATA_W-1:0] acc_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              q_flag
);
  localparam int MSB = DATA_W - 1;

  logic accept;
  assign accept = in_valid && (op_code inside {4'h8, 4'h9, 4'hB});

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!out_valid && !q_flag && result == '0); // R8
    end
  end

  generate
    if (REG_OUT) begin : g_seq
      AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid); // R7
      AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !out_valid); // R6
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(result) && $stable(q_flag))); // R6
      AST_Q_ONLY_MAC: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code != 4'h8) |=> !q_flag); // R4
      AST_Q_SIGN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == 4'h8) |=> (!q_flag || (result[MSB] != $past(acc_in[MSB])))); // R3
    end
  endgenerate
endmodule

bind hmac_unit hmac_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_hmac_unit.sv
module sim_hmac_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op_code;
  logic        pos_a;
  logic        pos_b;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [31:0] acc_in;
  logic        out_valid;
  logic [31:0] result;
  logic        q_flag;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] last_res;
  logic        last_q;

  hmac_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .pos_a(pos_a), .pos_b(pos_b), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .out_valid(out_valid), .result(result), .q_flag(q_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (op=%h pa=%0d pb=%0d a=%h b=%h acc=%h)",
               req, act, exp, op_code, pos_a, pos_b, src_a, src_b, acc_in);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Reference model, written from the requirements
  function automatic logic [32:0] model(input logic [3:0] op, input logic pa, input logic pb,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] acc);
    logic [15:0] ha = pa ? a[31:16] : a[15:0];
    logic [15:0] hb = pb ? b[31:16] : b[15:0];
    longint sa = longint'($signed(ha));
    longint sb = longint'($signed(hb));
    longint p;
    logic [63:0] pv;
    logic [31:0] s;
    logic q;
    if (op == 4'h9) begin
      p  = longint'($signed(a)) * sb;
      pv = p;
      return {1'b0, pv[47:16]};
    end
    p  = sa * sb;
    pv = p;
    if (op == 4'hB) return {1'b0, pv[31:0]};
    s = pv[31:0] + acc;
    q = (pv[31] == acc[31]) && (s[31] != pv[31]);
    return {q, s};
  endfunction

  task automatic apply(input string req, input logic [3:0] op, input logic pa, input logic pb,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc);
    logic [32:0] e;
    in_valid = 1'b1; op_code = op; pos_a = pa; pos_b = pb;
    src_a = a; src_b = b; acc_in = acc;
    e = model(op, pa, pb, a, b, acc);
    @(negedge clk);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " result"}, result, e[31:0]);
    check({req, " q"}, {31'd0, q_flag}, {31'd0, e[32]});
    last_res = e[31:0];
    last_q   = e[32];
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [15:0] hv [5];
    logic [31:0] av [4];
    logic [3:0]  ops [3];
    logic [31:0] lcg;
    hv[0] = 16'h0000; hv[1] = 16'h0001; hv[2] = 16'h7FFF; hv[3] = 16'h8000; hv[4] = 16'hFFFF;
    av[0] = 32'h0; av[1] = 32'h7FFFFFFF; av[2] = 32'h80000000; av[3] = 32'hFFFFFFFF;
    ops[0] = 4'h8; ops[1] = 4'h9; ops[2] = 4'hB;

    rst_n = 1'b0; in_valid = 1'b0; op_code = 4'h0; pos_a = 1'b0; pos_b = 1'b0;
    src_a = '0; src_b = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 valid", {31'd0, out_valid}, 32'd0);
    check("R8 result", result, 32'd0);
    check("R8 q", {31'd0, q_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: R1 half selection, R2/R3 accumulate, R4 multiply, R5 word mode
    for (int o = 0; o < 3; o++)
      for (int p = 0; p < 4; p++)
        for (int i = 0; i < 25; i++)
          for (int j = 0; j < 25; j++)
            for (int k = 0; k < 4; k++)
              apply(ops[o] == 4'h8 ? "R1 R2 R3" : (ops[o] == 4'h9 ? "R1 R5" : "R1 R4"),
                    ops[o], p[1], p[0],
                    {hv[i/5], hv[i%5]}, {hv[j/5], hv[j%5]}, av[k]);

    // Pseudo-random full-width vectors for R5 and R2
    lcg = 32'h1234_5678;
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] ra, rb, rc;
      lcg = lcg * 32'd1664525 + 32'd1013904223; ra = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; rb = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; rc = lcg;
      apply("R5 R2 R3 R4 rnd", ops[n % 3], rc[0], rc[1], ra, rb, rc);
    end

    // R6: illegal codes produce no valid and leave outputs unchanged
    for (int c = 0; c < 16; c++) begin
      if (c == 8 || c == 9 || c == 11) continue;
      in_valid = 1'b1; op_code = c[3:0]; src_a = 32'h7FFF7FFF; src_b = 32'h80008000;
      acc_in = 32'h7FFFFFFF;
      @(negedge clk);
      check("R6 valid", {31'd0, out_valid}, 32'd0);
      check("R6 result hold", result, last_res);
      check("R6 q hold", {31'd0, q_flag}, {31'd0, last_q});
    end

    // R7: idle cycles hold outputs and lower valid
    apply("R7 setup", 4'h8, 1'b1, 1'b0, 32'h7FFF0000, 32'h00007FFF, 32'h7FFFFFFF);
    in_valid = 1'b0; op_code = 4'hB; src_a = 32'h12345678;
    repeat (3) begin
      @(negedge clk);
      check("R7 valid low", {31'd0, out_valid}, 32'd0);
      check("R7 result hold", result, last_res);
      check("R7 q hold", {31'd0, q_flag}, {31'd0, last_q});
    end

    finish_up();
  end
endmodule